// File: doc/BRIEF.md
# Bus Error Status Capture Bank

This block keeps the error status for up to N bus masters, with N set by a parameter from 1 to 16. An error event arrives from the bus side on a one-cycle strobe. It carries the index of the master that saw the error, the failing address, the byte enables, a read/write flag and a lock qualifier. For each master the block holds four status bits: an error flag, an owner flag, a read flag and a lock flag. The owner flag marks the master whose address and byte enables sit in the single shared capture register. The read flag records whether the error came from a read or a write. The lock flag shows that this master froze the capture register.

Software reads the four 32-bit status words through a small register port. A 2-bit address selects the word, and the read data is combinational. Software clears a master's status by writing 1 to that master's bit in the error word. This clears all four status bits of that master. If that master held the lock, the same write also releases the capture register. An error word that reads as zero means no master has an outstanding error, so software has nothing more to read.

The block does not detect errors and does not arbitrate the bus. Apart from a one-cycle software-reset input, it has no control register.

Top module: `errstat_bank`

## Requirements
- R1: An accepted event from master m sets bit m of the error word (address 0). An event whose index is N or greater changes nothing.
- R2: Bit m of the read-flag word (address 2) takes the read/write flag of the most recent event from master m: 1 for a read, 0 for a write.
- R3: While the capture register is unlocked, an event loads its address and byte enables into the capture outputs on the next clock. The owner word (address 1) then holds exactly bit m.
- R4: An event with the lock qualifier high that is captured sets bit m of the lock word (address 3) and raises `cap_locked`. While `cap_locked` is high, later events still set their error and read-flag bits. They leave the captured address, byte enables, owner word and lock word unchanged.
- R5: A write to address 0 clears, for every data bit i below N that is 1, bit i of all four status words. Data bits that are 0 leave their masters unchanged.
- R6: Clearing the master that holds the lock drops `cap_locked`. The next event is then captured.
- R7: When a clear and an event for the same master fall in the same cycle, the event wins: the error bit ends set and the read flag takes the new value. Whether an event is captured depends on the lock state at the start of that cycle.
- R8: An active-low `rst_n` or a high `soft_rst` clears all four status words and the capture outputs. `soft_rst` takes priority over an event or a clear in the same cycle.
- R9: Address 0 reads the error word, 1 the owner word, 2 the read-flag word and 3 the lock word. Bit i belongs to master i, and bits N to 31 always read 0.
- R10: Writes to addresses 1, 2 and 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Software reset pulse, clears all status |
| err_valid | input | 1 | Error event strobe |
| err_master | input | IDX_W | Index of the reporting master |
| err_addr | input | ADDR_W | Failing address |
| err_be | input | BE_W | Failing byte enables |
| err_read | input | 1 | 1 = the failing transfer was a read |
| err_lock | input | 1 | Lock qualifier for this error |
| reg_addr | input | 2 | Status word select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data (write 1 to clear at address 0) |
| reg_rdata | output | 32 | Selected status word, combinational |
| cap_addr | output | ADDR_W | Captured address |
| cap_be | output | BE_W | Captured byte enables |
| cap_locked | output | 1 | Capture register is locked |

## Verification
The interesting collision is a software write-1-to-clear and a bus error event landing on the same master in the same clock. The bench drives both in one cycle: once while the master holds the lock, once while the capture register is free, and once with the clear aimed at the lock holder while a different master reports. A behavioural model applies the clear first and then the event, using the lock state taken at the start of the cycle. All four status words and the capture outputs are compared against that model after every edge. A randomised stretch then mixes events, clears and soft resets so that such coincidences also occur unplanned.

// File: rtl/errstat_pkg.sv
package errstat_pkg;
   localparam int STAT_W      = 32;
   localparam int MAX_MASTERS = 16;

   typedef enum logic [1:0] {
      SEL_DETECT = 2'd0,
      SEL_OWNER  = 2'd1,
      SEL_RDFLAG = 2'd2,
      SEL_LOCK   = 2'd3
   } stat_sel_e;
endpackage

// File: rtl/errstat_event_dec.sv
module errstat_event_dec
   import errstat_pkg::*;
#(
   parameter int N     = 6,
   parameter int IDX_W = 3
) (
   input  logic             ev_valid,
   input  logic [IDX_W-1:0] ev_master,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [N-1:0]     wr_bits,
   output logic [N-1:0]     hit,
   output logic [N-1:0]     clr
);
   logic clr_en;
   assign clr_en = wr_en && (stat_sel_e'(wr_sel) == SEL_DETECT);

   for (genvar g = 0; g < N; g++) begin : g_dec
      assign hit[g] = ev_valid && (ev_master == IDX_W'(g));
      assign clr[g] = clr_en && wr_bits[g];
   end
endmodule

// File: rtl/errstat_slice.sv
module errstat_slice (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic hit_i,
   input  logic clr_i,
   input  logic cap_i,
   input  logic rd_i,
   input  logic lk_i,
   output logic det_o,
   output logic own_o,
   output logic rnw_o,
   output logic lck_o
);
   logic det_q, own_q, rnw_q, lck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         det_q <= 1'b0;
         own_q <= 1'b0;
         rnw_q <= 1'b0;
         lck_q <= 1'b0;
      end else if (soft_rst) begin
         det_q <= 1'b0;
         own_q <= 1'b0;
         rnw_q <= 1'b0;
         lck_q <= 1'b0;
      end else begin
         det_q <= hit_i | (det_q & ~clr_i);
         rnw_q <= hit_i ? rd_i : (rnw_q & ~clr_i);
         if (cap_i) begin
            own_q <= hit_i;
            lck_q <= hit_i & lk_i;
         end else begin
            own_q <= own_q & ~clr_i;
            lck_q <= lck_q & ~clr_i;
         end
      end
   end

   assign det_o = det_q;
   assign own_o = own_q;
   assign rnw_o = rnw_q;
   assign lck_o = lck_q;

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !hit_i) |=> !det_q); // R5

   AST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_i && !soft_rst) |=> (det_q && (rnw_q == $past(rd_i)))); // R7
endmodule

// File: rtl/errstat_capture.sv
module errstat_capture #(
   parameter int ADDR_W = 32,
   parameter int BE_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BE_W-1:0]   be_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BE_W-1:0]   be_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o <= '0;
         be_o   <= '0;
      end else if (soft_rst) begin
         addr_o <= '0;
         be_o   <= '0;
      end else if (load) begin
         addr_o <= addr_i;
         be_o   <= be_i;
      end
   end
endmodule

// File: rtl/errstat_bank.sv
module errstat_bank
   import errstat_pkg::*;
#(
   parameter int N      = 6,
   parameter int ADDR_W = 32,
   parameter int BE_W   = 4,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              err_valid,
   input  logic [IDX_W-1:0]  err_master,
   input  logic [ADDR_W-1:0] err_addr,
   input  logic [BE_W-1:0]   err_be,
   input  logic              err_read,
   input  logic              err_lock,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [ADDR_W-1:0] cap_addr,
   output logic [BE_W-1:0]   cap_be,
   output logic              cap_locked
);
   if (N < 1 || N > MAX_MASTERS) begin : g_bad_n
      $error("errstat_bank: N must lie in 1..16");
   end
   if (ADDR_W < 1 || BE_W < 1) begin : g_bad_w
      $error("errstat_bank: ADDR_W and BE_W must be positive");
   end

   logic [N-1:0] hit, clr;
   logic [N-1:0] det_w, own_w, rnw_w, lck_w;
   logic         cap_now;

   errstat_event_dec #(.N(N), .IDX_W(IDX_W)) u_dec (
      .ev_valid  (err_valid),
      .ev_master (err_master),
      .wr_en     (reg_wr),
      .wr_sel    (reg_addr),
      .wr_bits   (reg_wdata[N-1:0]),
      .hit       (hit),
      .clr       (clr)
   );

   // lock state taken at the start of the cycle decides capture
   assign cap_locked = |lck_w;
   assign cap_now    = (|hit) && !cap_locked;

   for (genvar m = 0; m < N; m++) begin : g_master
      errstat_slice u_slice (
         .clk      (clk),
         .rst_n    (rst_n),
         .soft_rst (soft_rst),
         .hit_i    (hit[m]),
         .clr_i    (clr[m]),
         .cap_i    (cap_now),
         .rd_i     (err_read),
         .lk_i     (err_lock),
         .det_o    (det_w[m]),
         .own_o    (own_w[m]),
         .rnw_o    (rnw_w[m]),
         .lck_o    (lck_w[m])
      );
   end

   errstat_capture #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .load     (cap_now),
      .addr_i   (err_addr),
      .be_i     (err_be),
      .addr_o   (cap_addr),
      .be_o     (cap_be)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (stat_sel_e'(reg_addr))
         SEL_DETECT: reg_rdata[N-1:0] = det_w;
         SEL_OWNER:  reg_rdata[N-1:0] = own_w;
         SEL_RDFLAG: reg_rdata[N-1:0] = rnw_w;
         SEL_LOCK:   reg_rdata[N-1:0] = lck_w;
      endcase
   end

   AST_OWNER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(own_w)); // R3

   AST_LOCK_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
      ((lck_w & ~own_w) == '0)); // R4

   AST_STATUS_NEEDS_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
      (((own_w | rnw_w | lck_w) & ~det_w) == '0)); // R5

   AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_locked && !soft_rst) |=> ($stable(cap_addr) && $stable(cap_be))); // R4

   AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (det_w == '0 && !cap_locked)); // R8

   AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && !soft_rst && (32'(err_master) < N))
      |=> (|(det_w >> $past(err_master)))); // R1
endmodule

// File: tb/tb_errstat_bank.sv
module tb_errstat_bank;
   localparam int N  = 6;
   localparam int AW = 32;
   localparam int BW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          soft_rst = 1'b0;
   logic          err_valid = 1'b0;
   logic [2:0]    err_master = '0;
   logic [AW-1:0] err_addr = '0;
   logic [BW-1:0] err_be = '0;
   logic          err_read = 1'b0;
   logic          err_lock = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [AW-1:0] cap_addr;
   logic [BW-1:0] cap_be;
   logic          cap_locked;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;
   string sect = "R8";

   // reference model state
   bit          md[16], mo[16], mr[16], ml[16];
   logic [31:0] ma;
   logic [3:0]  mb;

   // 8 time units per period: 125 MHz with a 1 ns unit
   always #4 clk = ~clk;

   errstat_bank #(.N(N), .ADDR_W(AW), .BE_W(BW)) dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .err_valid(err_valid), .err_master(err_master), .err_addr(err_addr),
      .err_be(err_be), .err_read(err_read), .err_lock(err_lock),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .cap_addr(cap_addr), .cap_be(cap_be),
      .cap_locked(cap_locked)
   );

   function automatic logic [31:0] word_of(int sel);
      logic [31:0] w = '0;
      for (int i = 0; i < N; i++) begin
         case (sel)
            0: w[i] = md[i];
            1: w[i] = mo[i];
            2: w[i] = mr[i];
            default: w[i] = ml[i];
         endcase
      end
      return w;
   endfunction

   function automatic bit model_locked();
      for (int i = 0; i < N; i++) if (ml[i]) return 1'b1;
      return 1'b0;
   endfunction

   task automatic model_clear_all();
      for (int i = 0; i < 16; i++) begin
         md[i] = 0; mo[i] = 0; mr[i] = 0; ml[i] = 0;
      end
      ma = '0;
      mb = '0;
   endtask

   task automatic model_step();
      bit was_locked;
      int m;
      if (soft_rst) begin
         model_clear_all();
         return;
      end
      was_locked = model_locked();
      if (reg_wr && reg_addr == 2'd0) begin
         for (int i = 0; i < N; i++) begin
            if (reg_wdata[i]) begin
               md[i] = 0; mo[i] = 0; mr[i] = 0; ml[i] = 0;
            end
         end
      end
      m = int'(err_master);
      if (err_valid && m < N) begin
         md[m] = 1;
         mr[m] = err_read;
         if (!was_locked) begin
            for (int i = 0; i < 16; i++) mo[i] = 0;
            mo[m] = 1;
            ml[m] = err_lock;
            ma = err_addr;
            mb = err_be;
         end
      end
   endtask

   task automatic check(string what, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h", sect, what, act, exp);
      end
   endtask

   task automatic compare_all();
      reg_wr = 1'b0;
      for (int s = 0; s < 4; s++) begin
         reg_addr = 2'(s);
         #1;
         check($sformatf("word%0d (R9)", s), reg_rdata, word_of(s));
      end
      check("cap_addr (R3)", cap_addr, ma);
      check("cap_be (R3)", {28'd0, cap_be}, {28'd0, mb});
      check("cap_locked (R4)", {31'd0, cap_locked}, {31'd0, model_locked()});
   endtask

   task automatic cyc(bit v, int m, logic [31:0] a, logic [3:0] be, bit rd, bit lk,
                      bit wr, logic [1:0] wa, logic [31:0] wd, bit sr);
      err_valid = v; err_master = 3'(m); err_addr = a; err_be = be;
      err_read = rd; err_lock = lk;
      reg_wr = wr; reg_addr = wa; reg_wdata = wd; soft_rst = sr;
      @(posedge clk);
      model_step();
      #1;
      err_valid = 1'b0; soft_rst = 1'b0;
      reg_wr = 1'b0;
      compare_all();
   endtask

   task automatic ev(int m, logic [31:0] a, logic [3:0] be, bit rd, bit lk);
      cyc(1, m, a, be, rd, lk, 0, 2'd0, 32'd0, 0);
   endtask

   task automatic clr(logic [31:0] d);
      cyc(0, 0, 32'd0, 4'd0, 0, 0, 1, 2'd0, d, 0);
   endtask

   task automatic idle();
      cyc(0, 0, 32'd0, 4'd0, 0, 0, 0, 2'd0, 32'd0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      model_clear_all();
      repeat (3) @(posedge clk);
      #2;
      sect = "R8";
      compare_all();
      rst_n = 1'b1;
      @(negedge clk);
      idle();

      sect = "R1";
      ev(0, 32'h1000_0000, 4'h1, 1, 0);
      ev(3, 32'h1000_0030, 4'h3, 0, 0);
      ev(5, 32'h1000_0050, 4'hF, 1, 0);
      ev(6, 32'hDEAD_0006, 4'h5, 1, 1);    // index out of range, ignored
      ev(7, 32'hDEAD_0007, 4'h5, 0, 1);

      sect = "R2";
      ev(3, 32'h2000_0030, 4'h8, 1, 0);
      ev(0, 32'h2000_0000, 4'h2, 0, 0);

      sect = "R3";
      ev(2, 32'h3000_0020, 4'hC, 1, 0);
      ev(4, 32'h3000_0040, 4'h6, 0, 0);

      sect = "R10";
      cyc(0, 0, 0, 0, 0, 0, 1, 2'd1, 32'hFFFF_FFFF, 0);
      cyc(0, 0, 0, 0, 0, 0, 1, 2'd2, 32'hFFFF_FFFF, 0);
      cyc(0, 0, 0, 0, 0, 0, 1, 2'd3, 32'hFFFF_FFFF, 0);

      sect = "R5";
      clr(32'h0000_0000);
      clr(32'hFFFF_FF00 | 32'h0000_0001);
      clr(32'h0000_0010);

      sect = "R4";
      ev(1, 32'h4000_0010, 4'hA, 1, 1);
      ev(3, 32'h4000_0030, 4'h5, 0, 1);
      ev(5, 32'h4000_0050, 4'h3, 1, 0);
      clr(32'h0000_0008);

      sect = "R6";
      clr(32'h0000_0002);
      ev(4, 32'h5000_0040, 4'h9, 0, 0);

      sect = "R7";
      ev(2, 32'h6000_0020, 4'h1, 1, 1);           // lock by master 2
      cyc(1, 2, 32'h6000_0021, 4'h2, 0, 0, 1, 2'd0, 32'h0000_0004, 0);
      ev(1, 32'h6000_0010, 4'h4, 1, 1);           // lock by master 1
      cyc(1, 3, 32'h6000_0031, 4'h7, 1, 0, 1, 2'd0, 32'h0000_0002, 0);
      ev(0, 32'h6000_0001, 4'hE, 0, 0);           // unlocked now, captures
      cyc(1, 0, 32'h6000_0002, 4'hD, 1, 1, 1, 2'd0, 32'h0000_0001, 0);

      sect = "R8";
      cyc(1, 4, 32'h7000_0040, 4'hF, 1, 1, 1, 2'd0, 32'h0000_0001, 1);
      ev(3, 32'h7000_0030, 4'h3, 1, 1);
      cyc(0, 0, 0, 0, 0, 0, 0, 2'd0, 0, 1);

      sect = "R9";
      for (int k = 0; k < 6; k++) ev(k, 32'h8000_0000 + k, 4'(k), k[0], 0);
      clr(32'hFFFF_FFFF);

      sect = "R7 random";
      void'($urandom(32'h5EED));
      for (int k = 0; k < 600; k++) begin
         int r = $urandom_range(0, 99);
         cyc($urandom_range(0, 99) < 55, $urandom_range(0, 7), $urandom,
             4'($urandom), $urandom_range(0, 1), $urandom_range(0, 99) < 30,
             $urandom_range(0, 99) < 35, 2'($urandom_range(0, 3)),
             32'(1 << $urandom_range(0, 7)) | ((r < 10) ? 32'hFF : 32'h0),
             r > 96);
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule